// File: doc/BRIEF.md
# Signed Shift-Add Sequential Multiplier

This block multiplies two 8-bit two's-complement numbers over a series of clock cycles and presents a 16-bit signed product. It trades speed for area. Each clock it inspects one bit of the multiplier. When that bit is set, it adds a running, left-shifted copy of the multiplicand to the product.

Signed operation needs no special handling in the datapath. Both operands are widened to 16 bits by copying their sign bit into the upper byte. Sixteen plain unsigned shift-add steps then run, and anything that would carry above bit 15 is dropped. The low 16 bits that remain are exactly the signed product.

Operands are taken in only while reset is held high. Releasing reset starts the computation. A ready flag reports when all sixteen steps are done, and the product then stays frozen until the next reset. Reset is synchronous and active high.

Top module: `seq_signed_mul`

## Requirements
- R1: On any clock edge where `rst` is high, `p` becomes 0 and `rdy` becomes 0, and the current `a` and `b` are loaded, each sign-extended by copying bit 7 into bits 15..8.
- R2: After the 16th rising edge following reset release, `p` equals the 16-bit two's-complement product of the loaded `a` and `b`, for every combination of operand signs.
- R3: After the k-th rising edge following reset release (k = 1..16), `p` equals (sign-extended `b`) × (sign-extended `a` with only bits k-1..0 kept), taken modulo 2^16. Operand `a` supplies the multiplier bits, least significant bit first, and the multiplicand copy moves left by exactly one place per step.
- R4: `rdy` stays 0 through the 16th edge after reset release and becomes 1 on the 17th.
- R5: While `rdy` is 1 and `rst` is low, `rdy` stays 1 and `p` does not change.
- R6: Changes on `a` and `b` while `rst` is low have no effect on `p` or `rdy`.
- R7: The corner products -128×2 = -256, 10×-128 = -1280, -1×-1 = 1, 10×0 = 0 and -128×-128 = 16384 come out exact.
- R8: Asserting `rst` part-way through a computation abandons it. Afterwards the new operands are multiplied from scratch with the timing of R2 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; operands load while it is high |
| a | input | 8 | Multiplier operand, two's complement |
| b | input | 8 | Multiplicand operand, two's complement |
| p | output | 16 | Signed product (partial sum until `rdy`) |
| rdy | output | 1 | High once all sixteen steps are done |

## Verification
The clock edge on which `rst` is first sampled low is counted as edge 1. The partial sum is due on each of edges 1 through 16. The final product is due on edge 16, and `rdy` is due on edge 17, one register stage later.

The bench drives inputs and samples outputs on the falling edge after each counted rising edge. Every partial sum is therefore compared against the prefix model of R3 in the cycle it becomes valid. `rdy` is checked both low on edge 16 and high on edge 17, so an off-by-one in either direction is caught.

The checker keeps its own edge count since reset and requires `rdy` to match that count on every cycle.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

    localparam int OP_W_DEF = 8;

    // Sign-extend an operand into the full product width.
    function automatic logic [2*OP_W_DEF-1:0] widen(input logic [OP_W_DEF-1:0] v);
        return {{OP_W_DEF{v[OP_W_DEF-1]}}, v};
    endfunction

    typedef struct packed {
        logic [2*OP_W_DEF-1:0] mcand;
        logic [2*OP_W_DEF-1:0] mplier;
    } opnd_t;

endpackage

// File: rtl/seq_mul_operands.sv
module seq_mul_operands
    import seq_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [OP_W_DEF-1:0] a,
    input  logic [OP_W_DEF-1:0] b,
    output opnd_t             opnd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd.mplier <= widen(a);
            opnd.mcand  <= widen(b);
        end else if (step_en) begin
            // one place per step, independent of the add decision
            opnd.mcand  <= opnd.mcand << 1;
        end
    end

endmodule

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl #(
    parameter int STEPS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [STEPS-1:0] mplier,
    output logic             step_en,
    output logic             add_bit,
    output logic             rdy
);

    localparam int CNT_W = $clog2(STEPS + 1);

    logic [CNT_W-1:0] step_q;

    assign step_en = (step_q < CNT_W'(STEPS));

    // select the multiplier bit for the current step
    always_comb begin
        add_bit = 1'b0;
        for (int i = 0; i < STEPS; i++) begin
            if (step_q == CNT_W'(i)) add_bit = mplier[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            rdy    <= 1'b0;
        end else if (step_en) begin
            step_q <= step_q + 1'b1;
        end else begin
            rdy    <= 1'b1;
        end
    end

endmodule

// File: rtl/seq_mul_accum.sv
module seq_mul_accum #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          add_bit,
    input  logic [PW-1:0] mcand,
    output logic [PW-1:0] acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (step_en && add_bit) begin
            // uses the multiplicand from before this edge's shift; carry out dropped
            acc <= acc + mcand;
        end
    end

endmodule

// File: rtl/seq_signed_mul.sv
module seq_signed_mul
    import seq_mul_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [OP_W_DEF-1:0]   a,
    input  logic [OP_W_DEF-1:0]   b,
    output logic [2*OP_W_DEF-1:0] p,
    output logic                  rdy
);

    localparam int PW = 2 * OP_W_DEF;

    opnd_t opnd;
    logic  step_en;
    logic  add_bit;

    seq_mul_operands u_opnd (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .a       (a),
        .b       (b),
        .opnd    (opnd)
    );

    seq_mul_ctrl #(.STEPS(PW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .mplier  (opnd.mplier),
        .step_en (step_en),
        .add_bit (add_bit),
        .rdy     (rdy)
    );

    seq_mul_accum #(.PW(PW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .add_bit (add_bit),
        .mcand   (opnd.mcand),
        .acc     (p)
    );

endmodule

// File: rtl/seq_signed_mul_chk.sv
module seq_signed_mul_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] p,
    input logic        rdy
);

    logic [4:0] edges_q;

    always_ff @(posedge clk) begin
        if (rst)                 edges_q <= '0;
        else if (edges_q != 5'd31) edges_q <= edges_q + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (p == 16'h0 && !rdy));

    // R4
    rdy_early_chk: assert property (@(posedge clk) disable iff (rst)
        (edges_q < 5'd17) |-> !rdy);

    // R4
    rdy_due_chk: assert property (@(posedge clk) disable iff (rst)
        (edges_q >= 5'd17) |-> rdy);

    // R5
    rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |=> rdy);

    // R5
    p_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |=> $stable(p));

endmodule

bind seq_signed_mul seq_signed_mul_chk u_chk (
    .clk (clk),
    .rst (rst),
    .p   (p),
    .rdy (rdy)
);

// File: tb/seq_signed_mul_tb_top.sv
module seq_signed_mul_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  a = 8'h00;
    logic [7:0]  b = 8'h00;
    logic [15:0] p;
    logic        rdy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    seq_signed_mul dut_i (.clk(clk), .rst(rst), .a(a), .b(b), .p(p), .rdy(rdy));

    // {a, b, expected product}
    localparam logic [31:0] VEC [10] = '{
        {8'h05, 8'h05, 16'h0019},
        {8'h02, 8'h03, 16'h0006},
        {8'h80, 8'h02, 16'hFF00},
        {8'h0A, 8'h80, 16'hFB00},
        {8'hFF, 8'hFF, 16'h0001},
        {8'h0A, 8'h00, 16'h0000},
        {8'h80, 8'h80, 16'h4000},
        {8'h7F, 8'hFF, 16'hFF81},
        {8'h7F, 8'h7F, 16'h3F01},
        {8'hFD, 8'h07, 16'hFFEB}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] prefix(input logic [7:0] ma, input logic [7:0] mb, input int k);
        logic [15:0] ea, eb, mask;
        ea   = {{8{ma[7]}}, ma};
        eb   = {{8{mb[7]}}, mb};
        mask = (k >= 16) ? 16'hFFFF : 16'((32'd1 << k) - 1);
        return 16'(eb * (ea & mask));
    endfunction

    task automatic load(input logic [7:0] ia, input logic [7:0] ib);
        @(negedge clk);
        rst = 1'b1; a = ia; b = ib;
        @(posedge clk);
        @(negedge clk);
        chk(p == 16'h0, "R1 p", p, 0);
        chk(rdy == 1'b0, "R1 rdy", rdy, 0);
        rst = 1'b0;
    endtask

    task automatic run(input logic [7:0] ia, input logic [7:0] ib, input logic [15:0] exp, input string tag);
        load(ia, ib);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            chk(p == prefix(ia, ib, k), "R3 partial", p, prefix(ia, ib, k));
        end
        chk(p == exp, tag, p, exp);
        chk(rdy == 1'b0, "R4 rdy low at edge 16", rdy, 0);
        @(negedge clk);
        chk(rdy == 1'b1, "R4 rdy at edge 17", rdy, 1);
        chk(p == exp, "R5 p hold", p, exp);
        // R6: operand changes with reset low are ignored
        a = ~ia; b = ib + 8'd3;
        repeat (4) @(negedge clk);
        chk(p == exp, "R6 p after operand change", p, exp);
        chk(rdy == 1'b1, "R5 rdy hold", rdy, 1);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        for (int i = 0; i < 10; i++) begin
            run(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], "R2 final product");
        end
        // R7 directed corners
        run(8'h80, 8'h02, 16'hFF00, "R7 -128*2");
        run(8'h0A, 8'h80, 16'hFB00, "R7 10*-128");
        run(8'hFF, 8'hFF, 16'h0001, "R7 -1*-1");
        run(8'h0A, 8'h00, 16'h0000, "R7 10*0");
        run(8'h80, 8'h80, 16'h4000, "R7 -128*-128");
        // R8: abort part-way, then restart with new operands
        load(8'h55, 8'h33);
        repeat (7) @(negedge clk);
        chk(rdy == 1'b0, "R8 rdy mid-run", rdy, 0);
        run(8'hE0, 8'h11, 16'hFDE0, "R8 restart product");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule